// File: doc/BRIEF.md
# Banked Window Address Decoder

This block sits on the 16-bit address bus of an 8-bit processor and splits its address space into local regions: a mirrored 8 KB RAM, a four-register sound device, a video port, a bank-control location and a 32 KB upper window. The window maps onto a 24-bit external space. The upper nine address bits come from a bank register, and the CPU supplies the lower fifteen.

The bank register is loaded serially. Each write to the bank-control range shifts the register right by one place and inserts bit 0 of the written byte at the top. Nine such writes therefore set the whole register, with the first bit written ending up in bit 0. Window accesses land in ROM when the bank value is small, and in 64 KB of work RAM when the external address lies at 0xE00000 or above. The external targets are 16 bits wide, so every byte access through the window has its lowest address bit inverted, which swaps the byte lanes.

All region decoding and read-data selection is combinational from the address. The only clocked state is the bank register and a one-cycle flag that reports window writes that reach no writable target.

Top module: `bank_window_decoder`

## Requirements
- R1: While a strobe is active, an address in 0x0000–0x3FFF asserts `ram_sel`. `ram_addr` carries CPU address bits [12:0], so the 8 KB RAM appears twice, and a read returns `ram_rdata`.
- R2: While a strobe is active, an address in 0x4000–0x5FFF asserts `snd_sel`. `snd_addr` carries address bits [1:0], and a read returns `snd_rdata`.
- R3: While a strobe is active, an address in 0x7F00–0x7FFF asserts `vid_sel`. `vid_addr` carries address bits [7:0], and a read returns `vid_rdata`.
- R4: The 9-bit bank register resets to 0. On each clock edge that sees `cpu_wr` with an address in 0x6000–0x60FF, the new value is {data bit 0, old value bits [8:1]}. The register is visible as `ext_addr[23:15]`.
- R5: A read of 0x6000–0x60FF returns 0x00 and leaves the bank register unchanged.
- R6: Addresses 0x6100–0x7EFF assert no select, and a read there returns 0xFF.
- R7: `ext_addr` always equals {bank, CPU address bits [14:1], inverted CPU address bit 0}.
- R8: A read in 0x8000–0xFFFF while the bank value is below 0x80 asserts `rom_sel` and returns `rom_rdata`. ROM is never selected by a write.
- R9: When the bank value is 0x1C0 or above, a window read or write asserts `wram_sel`. `wram_addr` equals `ext_addr[15:0]`, and a read returns `wram_rdata`.
- R10: A window read that hits neither ROM nor work RAM returns 0x00. A window write that does not reach work RAM, including a write aimed at ROM, raises `unhandled_wr` for exactly the following cycle.
- R11: Without `cpu_rd` or `cpu_wr`, no select is asserted. At most one select is asserted at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| ram_rdata | input | 8 | Local RAM read data |
| snd_rdata | input | 8 | Sound device read data |
| vid_rdata | input | 8 | Video port read data |
| rom_rdata | input | 8 | ROM read data |
| wram_rdata | input | 8 | Work RAM read data |
| ram_sel | output | 1 | Local RAM select |
| ram_addr | output | 13 | Local RAM address |
| snd_sel | output | 1 | Sound device select |
| snd_addr | output | 2 | Sound register index |
| vid_sel | output | 1 | Video port select |
| vid_addr | output | 8 | Video port offset |
| ext_addr | output | 24 | External address (bank plus lane-swapped offset) |
| rom_sel | output | 1 | ROM select (reads only) |
| wram_sel | output | 1 | Work RAM select |
| wram_addr | output | 16 | Work RAM address |
| cpu_rdata | output | 8 | Read data to CPU |
| unhandled_wr | output | 1 | One-cycle flag for a window write that reached nothing |

## Verification
The hardest cases to reach are the gap between the ROM limit (0x7F) and the work RAM base (0x1C0) and the top of the bank range. Each of them takes a run of nine serial writes with the bits ordered lowest first. The bench uses a loader task that emits those nine writes from a target value. Its reference model tracks every intermediate shift, so each partially loaded value is also checked through `ext_addr`. A read of the bank-control range is inserted between loads to confirm that it does not disturb the register.

// File: rtl/bwd_pkg.sv
package bwd_pkg;
  typedef enum logic [2:0] {
    RG_NONE,
    RG_RAM,
    RG_SND,
    RG_BANKCTL,
    RG_VID,
    RG_WIN
  } region_t;
endpackage

// File: rtl/bwd_region_decode.sv
module bwd_region_decode
  import bwd_pkg::*;
(
  input  logic [15:0] addr,
  output region_t     region
);
  always_comb begin
    if (addr[15])                       region = RG_WIN;
    else if (addr[15:14] == 2'b00)      region = RG_RAM;
    else if (addr[15:13] == 3'b010)     region = RG_SND;
    else if (addr[15:8] == 8'h60)       region = RG_BANKCTL;
    else if (addr[15:8] == 8'h7F)       region = RG_VID;
    else                                region = RG_NONE;
  end
endmodule

// File: rtl/bwd_bank_reg.sv
module bwd_bank_reg #(
  parameter int BANK_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              bit_in,
  output logic [BANK_W-1:0] bank
);
  always_ff @(posedge clk) begin
    if (rst)       bank <= '0;
    else if (load) bank <= {bit_in, bank[BANK_W-1:1]};
  end

  AST_BANK_SHIFT: assert property (@(posedge clk) disable iff (rst)
    load |=> bank == {$past(bit_in), $past(bank[BANK_W-1:1])}); // R4
  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(bank)); // R5
endmodule

// File: rtl/bwd_window_map.sv
module bwd_window_map #(
  parameter int BANK_W     = 9,
  parameter int WIN_W      = 15,
  parameter int ROM_BANKS  = 128,
  parameter int WRAM_BASE  = 448,
  localparam int EXT_W     = BANK_W + WIN_W
) (
  input  logic [BANK_W-1:0] bank,
  input  logic [WIN_W-1:0]  offset,
  output logic [EXT_W-1:0]  ext_addr,
  output logic              rom_hit,
  output logic              wram_hit
);
  localparam logic [BANK_W-1:0] ROM_LIM  = BANK_W'(ROM_BANKS);
  localparam logic [BANK_W-1:0] WRAM_LIM = BANK_W'(WRAM_BASE);

  // byte lanes of the 16-bit targets are swapped by inverting bit 0
  assign ext_addr = {bank, offset[WIN_W-1:1], ~offset[0]};
  assign rom_hit  = bank < ROM_LIM;
  assign wram_hit = bank >= WRAM_LIM;
endmodule

// File: rtl/bank_window_decoder.sv
module bank_window_decoder
  import bwd_pkg::*;
#(
  parameter int BANK_W    = 9,
  parameter int WIN_W     = 15,
  parameter int RAM_AW    = 13,
  parameter int SND_AW    = 2,
  parameter int VID_AW    = 8,
  parameter int WRAM_AW   = 16,
  parameter int ROM_BANKS = 128,
  parameter int WRAM_BASE = 448
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [15:0]              cpu_addr,
  input  logic [7:0]               cpu_wdata,
  input  logic                     cpu_rd,
  input  logic                     cpu_wr,
  input  logic [7:0]               ram_rdata,
  input  logic [7:0]               snd_rdata,
  input  logic [7:0]               vid_rdata,
  input  logic [7:0]               rom_rdata,
  input  logic [7:0]               wram_rdata,
  output logic                     ram_sel,
  output logic [RAM_AW-1:0]        ram_addr,
  output logic                     snd_sel,
  output logic [SND_AW-1:0]        snd_addr,
  output logic                     vid_sel,
  output logic [VID_AW-1:0]        vid_addr,
  output logic [BANK_W+WIN_W-1:0]  ext_addr,
  output logic                     rom_sel,
  output logic                     wram_sel,
  output logic [WRAM_AW-1:0]       wram_addr,
  output logic [7:0]               cpu_rdata,
  output logic                     unhandled_wr
);
  region_t           region;
  logic [BANK_W-1:0] bank;
  logic              rom_hit, wram_hit, strobe, in_win;
  logic              unused_wdata;

  assign unused_wdata = ^cpu_wdata[7:1];
  assign strobe = cpu_rd | cpu_wr;
  assign in_win = (region == RG_WIN);

  bwd_region_decode u_dec (.addr(cpu_addr), .region(region));

  bwd_bank_reg #(.BANK_W(BANK_W)) u_bank (
    .clk(clk), .rst(rst),
    .load(cpu_wr && region == RG_BANKCTL),
    .bit_in(cpu_wdata[0]),
    .bank(bank)
  );

  bwd_window_map #(.BANK_W(BANK_W), .WIN_W(WIN_W),
                   .ROM_BANKS(ROM_BANKS), .WRAM_BASE(WRAM_BASE)) u_map (
    .bank(bank), .offset(cpu_addr[WIN_W-1:0]),
    .ext_addr(ext_addr), .rom_hit(rom_hit), .wram_hit(wram_hit)
  );

  assign ram_sel   = strobe && region == RG_RAM;
  assign snd_sel   = strobe && region == RG_SND;
  assign vid_sel   = strobe && region == RG_VID;
  assign rom_sel   = cpu_rd && in_win && rom_hit;
  assign wram_sel  = strobe && in_win && wram_hit;
  assign ram_addr  = cpu_addr[RAM_AW-1:0];
  assign snd_addr  = cpu_addr[SND_AW-1:0];
  assign vid_addr  = cpu_addr[VID_AW-1:0];
  assign wram_addr = ext_addr[WRAM_AW-1:0];

  always_comb begin
    unique case (region)
      RG_RAM:     cpu_rdata = ram_rdata;
      RG_SND:     cpu_rdata = snd_rdata;
      RG_VID:     cpu_rdata = vid_rdata;
      RG_BANKCTL: cpu_rdata = 8'h00;
      RG_WIN:     cpu_rdata = rom_hit  ? rom_rdata  :
                              wram_hit ? wram_rdata : 8'h00;
      default:    cpu_rdata = 8'hFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) unhandled_wr <= 1'b0;
    else     unhandled_wr <= cpu_wr && in_win && !wram_hit;
  end

  AST_ONE_SEL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ram_sel, snd_sel, vid_sel, rom_sel, wram_sel})); // R11
  AST_SEL_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
    (ram_sel | snd_sel | vid_sel | rom_sel | wram_sel) |-> (cpu_rd | cpu_wr)); // R11
  AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (rst)
    unhandled_wr |-> $past(cpu_wr && cpu_addr[15] && !wram_sel)); // R10
  AST_ROM_DATA: assert property (@(posedge clk) disable iff (rst)
    rom_sel |-> cpu_rdata == rom_rdata); // R8
  AST_HOLE_FF: assert property (@(posedge clk) disable iff (rst)
    (cpu_addr[15:13] == 3'b011 && cpu_addr[15:8] != 8'h60 && cpu_addr[15:8] != 8'h7F)
      |-> cpu_rdata == 8'hFF); // R6
endmodule

// File: tb/sim_bank_window_decoder.sv
`timescale 1ns/1ps
module sim_bank_window_decoder;
  logic clk = 1'b0, rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [7:0] ram_rdata = 8'h11, snd_rdata = 8'h22, vid_rdata = 8'h33,
              rom_rdata = 8'h44, wram_rdata = 8'h55;
  logic ram_sel, snd_sel, vid_sel, rom_sel, wram_sel, unhandled_wr;
  logic [12:0] ram_addr;
  logic [1:0]  snd_addr;
  logic [7:0]  vid_addr, cpu_rdata;
  logic [23:0] ext_addr;
  logic [15:0] wram_addr;

  int total = 0, bad = 0;
  int mbank = 0;
  bit mflag = 0;

  always #4 clk = ~clk;

  bank_window_decoder u0 (.*);

  task automatic chk(input string req, input int act, input int exp, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input int a, input int d, input bit r, input bit w);
    int ea, er;
    bit win, st;
    string rtag;
    @(negedge clk);
    cpu_addr = 16'(a); cpu_wdata = 8'(d); cpu_rd = r; cpu_wr = w;
    #3;
    st  = r | w;
    win = a >= 'h8000;
    ea  = (mbank << 15) | ((a & 'h7FFF) ^ 1);
    chk("R7", int'(ext_addr), ea, "ext_addr");
    chk("R1", int'(ram_sel), int'(st && a < 'h4000), "ram_sel");
    chk("R2", int'(snd_sel), int'(st && a >= 'h4000 && a < 'h6000), "snd_sel");
    chk("R3", int'(vid_sel), int'(st && a >= 'h7F00 && a < 'h8000), "vid_sel");
    chk("R8", int'(rom_sel), int'(r && win && mbank < 'h80), "rom_sel");
    chk("R9", int'(wram_sel), int'(st && win && mbank >= 'h1C0), "wram_sel");
    chk("R10", int'(unhandled_wr), int'(mflag), "unhandled_wr");
    if (a < 'h4000) chk("R1", int'(ram_addr), a & 'h1FFF, "ram_addr");
    else if (a < 'h6000) chk("R2", int'(snd_addr), a & 3, "snd_addr");
    else if (a >= 'h7F00 && !win) chk("R3", int'(vid_addr), a & 'hFF, "vid_addr");
    if (win && mbank >= 'h1C0) chk("R9", int'(wram_addr), ea & 'hFFFF, "wram_addr");
    if (a < 'h4000)            begin er = 'h11; rtag = "R1"; end
    else if (a < 'h6000)       begin er = 'h22; rtag = "R2"; end
    else if (a < 'h6100)       begin er = 'h00; rtag = "R5"; end
    else if (a < 'h7F00)       begin er = 'hFF; rtag = "R6"; end
    else if (!win)             begin er = 'h33; rtag = "R3"; end
    else if (mbank < 'h80)     begin er = 'h44; rtag = "R8"; end
    else if (mbank >= 'h1C0)   begin er = 'h55; rtag = "R9"; end
    else                       begin er = 'h00; rtag = "R10"; end
    chk(rtag, int'(cpu_rdata), er, "cpu_rdata");
    @(posedge clk);
    mflag = w && win && mbank < 'h1C0;
    if (w && a >= 'h6000 && a < 'h6100) mbank = ((d & 1) << 8) | (mbank >> 1);
  endtask

  task automatic set_bank(input int v);
    for (int i = 0; i < 9; i++) step('h6000 + i, (v >> i) & 1, 0, 1);
  endtask

  task automatic probe(input string req, input int exp);
    step('h8000, 0, 0, 0);
    chk(req, int'(ext_addr[23:15]), exp, "bank");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    probe("R4", 0);                       // reset value
    step('h0000, 0, 1, 0); step('h2ABC, 0, 1, 0); step('h3FFF, 7, 0, 1);  // R1 mirror
    step('h4000, 0, 1, 0); step('h5FFF, 1, 0, 1); step('h4002, 0, 1, 0);  // R2
    step('h7F00, 0, 1, 0); step('h7FA5, 2, 0, 1);                         // R3
    step('h6100, 0, 1, 0); step('h7EFF, 0, 1, 0); step('h6123, 1, 0, 1);  // R6
    step('h8000, 0, 1, 0); step('hFFFF, 0, 1, 0);                         // R8 bank 0
    step('h8001, 9, 0, 1); step('h0010, 0, 1, 0);                         // R10 rom write
    set_bank('h07F); probe("R4", 'h07F);
    step('hC123, 0, 1, 0); step('hFFFE, 0, 1, 0);                         // R8 top rom bank
    set_bank('h080); probe("R4", 'h080);
    step('h9000, 0, 1, 0); step('h9001, 3, 0, 1); step('h9002, 3, 0, 1);  // R10 gap
    step('h1000, 0, 1, 0);
    step('h6000, 'hFF, 1, 0); step('h60FF, 'hFF, 1, 0); probe("R5", 'h080);
    set_bank('h1C0); probe("R4", 'h1C0);
    step('h8000, 0, 1, 0); step('hABCD, 5, 0, 1); step('hABCC, 0, 1, 0);  // R9
    step('h2000, 0, 1, 0);                                                // R10 no flag
    set_bank('h1FF); probe("R4", 'h1FF);
    step('hFFFF, 1, 0, 1);
    step('h6050, 'hFE, 0, 1); probe("R4", 'h0FF);                         // R4 single shift
    step('h1234, 0, 0, 0); step('h4001, 0, 0, 0); step('h7F10, 0, 0, 0);  // R11 no strobe
    step('h8000, 0, 0, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule